// File: doc/BRIEF.md
# Multi-channel RC servo pulse generator

This block drives a bank of hobby-servo control outputs from one shared frame timer. Software sets one frame length and one high-time per channel through a register write port. Both values count clock ticks of 20 ns each, so a 20 ms frame is 1,000,000 ticks. A configuration word holds one enable bit per channel and one global run bit. Every output that is enabled goes high at the start of each frame and stays high for its programmed number of ticks.

The configuration word, the frame length and every high-time can be read back on a separate combinational read port. Software can therefore switch single channels on or off by read-modify-write. A new frame length or high-time is staged and takes effect only at the next frame boundary, so a pulse that is already running is never cut short or stretched. Enable bits act at once.

Top module: `servo_pulse_bank`

## Requirements
- R1: While reset (rst_n low) is sampled at a rising edge, every register clears to 0. After reset, all readable registers read 0, all outputs are low, and the frame counter stays stopped until the global run bit is set.
- R2: Register map on wr_addr/rd_addr. Address 0 is the frame length. Address 1 is the configuration word: bit i enables channel i, and bit NUM_CH is the global run bit. Address 2+i is the high-time of channel i. A read returns the last value written, truncated to CNT_W bits for the length and high-times and to NUM_CH+1 bits for the configuration, with the upper bits zero. A write takes effect at the edge where wr_en is sampled.
- R3: While the run bit is set, the frame counter counts 0, 1, ..., period-1 and then wraps to 0. In the cycle after the k-th rising edge since the run bit became set, an enabled output is high exactly when (k mod period) is less than its high-time.
- R4: A channel output is high only when both its own enable bit and the global run bit are set. Enable bits take effect in the cycle after their write.
- R5: A high-time of 0 keeps the output low for the whole frame. A high-time equal to or larger than the period keeps it high for the whole frame.
- R6: A frame length or high-time written while the timer runs does not change the frame in progress. It is used from the next frame start on.
- R7: Clearing the global run bit forces all outputs low and holds the counter at 0. Setting the run bit again starts a fresh frame at count 0, using the values written up to that edge.
- R8: Writes to addresses above 1+NUM_CH change no register and no output. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per period |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | DATA_W | Combinational read data |
| servo_out | output | NUM_CH | Pulse output, one bit per channel |

## Verification
Register contents are due at the read port in the cycle right after the edge that captures the write. The outputs depend only on registered state, so the effect of an edge shows on the outputs in the half cycle that follows it. The bench drives its inputs on the falling edge, steps a behavioural model of the frame position once per rising edge, and compares outputs and read data on the next falling edge. A staged frame length or high-time is held pending in the model until its frame-boundary edge, so every comparison lands on the exact cycle of the change.

// File: rtl/servo_pkg.sv
// Package: shared register address map for the servo pulse bank.
// Assumes: the on-time registers of all channels sit at consecutive addresses.
package servo_pkg;
    localparam int PERIOD_ADDR      = 0;  // shared frame length
    localparam int CONFIG_ADDR      = 1;  // enables and global run bit
    localparam int ONTIME_BASE_ADDR = 2;  // first channel high-time
endpackage

// File: rtl/servo_regfile.sv
// Module: servo_regfile
// Holds the programmed frame length, the configuration word and one high-time
// per channel. It decodes writes and serves combinational reads.
// Assumes: CNT_W and NUM_CH+1 are both smaller than DATA_W.
module servo_regfile #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    output logic [CNT_W-1:0]                period_q,
    output logic [NUM_CH:0]                 cfg_q,
    output logic [NUM_CH-1:0][CNT_W-1:0]    on_q
);
    import servo_pkg::*;

    // Upper write-data bits are not stored anywhere.
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    // Purpose: capture the shared frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(PERIOD_ADDR))
            period_q <= wr_data[CNT_W-1:0];
    end

    // Purpose: capture the per-channel enables and the global run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(CONFIG_ADDR))
            cfg_q <= wr_data[NUM_CH:0];
    end

    // One high-time register for each channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ontime
        // Purpose: capture the high-time of channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                on_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ONTIME_BASE_ADDR + g))
                on_q[g] <= wr_data[CNT_W-1:0];
        end
    end

    // Purpose: return the addressed register, or zero for an unmapped address.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(PERIOD_ADDR))
            rd_data[CNT_W-1:0] = period_q;
        else if (rd_addr == ADDR_W'(CONFIG_ADDR))
            rd_data[NUM_CH:0] = cfg_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(ONTIME_BASE_ADDR + i))
                rd_data[CNT_W-1:0] = on_q[i];
        end
    end
endmodule

// File: rtl/servo_frame_timer.sv
// Module: servo_frame_timer
// The shared frame counter. It counts from 0 to period-1 while run is set and
// is held at 0 otherwise. The active period is reloaded whenever the timer is
// idle and at each frame wrap.
// Assumes: a period of 0 or 1 gives a one-tick frame.
module servo_frame_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period_new,
    output logic [CNT_W-1:0] frame_cnt,
    output logic [CNT_W-1:0] period_act,
    output logic             frame_wrap,
    output logic             load
);
    logic [CNT_W:0] cnt_inc;

    // One extra bit keeps the comparison exact at the top of the counter range.
    assign cnt_inc    = {1'b0, frame_cnt} + 1'b1;
    assign frame_wrap = run && (cnt_inc >= {1'b0, period_act});
    assign load       = !run || frame_wrap;

    // Purpose: step the frame counter and restart it at each wrap or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (load)
            frame_cnt <= '0;
        else
            frame_cnt <= frame_cnt + 1'b1;
    end

    // Purpose: move the staged period into use at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_act <= '0;
        else if (load)
            period_act <= period_new;
    end
endmodule

// File: rtl/servo_channel.sv
// Module: servo_channel
// One output. It keeps a working copy of its high-time and drives high while
// the shared counter is below that copy and the channel is enabled.
// Assumes: load comes from the frame timer and marks frame boundaries.
module servo_channel #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             enable,
    input  logic [CNT_W-1:0] on_new,
    input  logic [CNT_W-1:0] frame_cnt,
    output logic [CNT_W-1:0] on_act,
    output logic             pulse
);
    // Purpose: move the staged high-time into use at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            on_act <= '0;
        else if (load)
            on_act <= on_new;
    end

    // Purpose: form the output level from the enable and the frame position.
    assign pulse = enable && (frame_cnt < on_act);
endmodule

// File: rtl/servo_pulse_bank.sv
// Module: servo_pulse_bank (top)
// A bank of NUM_CH servo pulse outputs that share one frame timer. It contains
// the register file, the frame timer and one channel slice per output.
// Assumes: one clock tick is the unit for the period and for all high-times.
module servo_pulse_bank #(
    parameter int  NUM_CH = 8,
    parameter int  CNT_W  = 20,
    parameter int  DATA_W = 32,
    localparam int ADDR_W = $clog2(NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] servo_out
);
    logic [CNT_W-1:0]             period_q;
    logic [NUM_CH:0]              cfg_q;
    logic [NUM_CH-1:0][CNT_W-1:0] on_q;
    logic [NUM_CH-1:0][CNT_W-1:0] on_act;
    logic [CNT_W-1:0]             frame_cnt;
    logic [CNT_W-1:0]             period_act;
    logic                         frame_wrap;
    logic                         load;
    logic                         run;

    assign run = cfg_q[NUM_CH];

    servo_regfile #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .period_q(period_q), .cfg_q(cfg_q), .on_q(on_q)
    );

    servo_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .period_new(period_q),
        .frame_cnt(frame_cnt), .period_act(period_act),
        .frame_wrap(frame_wrap), .load(load)
    );

    // One channel slice for each output.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        servo_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .load(load),
            .enable(run && cfg_q[g]), .on_new(on_q[g]),
            .frame_cnt(frame_cnt), .on_act(on_act[g]), .pulse(servo_out[g])
        );
    end
endmodule

// File: rtl/servo_pulse_checker.sv
// Module: servo_pulse_checker
// Property checks on the servo pulse bank. The bind at the end of this file
// attaches it to every instance of the top module.
module servo_pulse_checker #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 20
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            servo_out,
    input logic [NUM_CH:0]              cfg_q,
    input logic [CNT_W-1:0]             frame_cnt,
    input logic [CNT_W-1:0]             period_act,
    input logic                         frame_wrap,
    input logic [NUM_CH-1:0][CNT_W-1:0] on_act
);
    // R1: a reset edge leaves the outputs, the counter and the configuration clear.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (servo_out == '0 && frame_cnt == '0 && cfg_q == '0));

    // R3: while running, the counter stays inside the active frame.
    a_r3_cnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[NUM_CH] && period_act != '0) |-> frame_cnt < period_act);

    // R4: no output is high unless its own enable bit is set.
    a_r4_chan_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_out & ~cfg_q[NUM_CH-1:0]) == '0);

    // R4: no output is high unless the global run bit is set.
    a_r4_global_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_out != '0) |-> cfg_q[NUM_CH]);

    // R6: the active period does not change inside a running frame.
    a_r6_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[NUM_CH] && !frame_wrap) |=> $stable(period_act));

    // R7: while the run bit is clear, the counter sits at 0.
    a_r7_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[NUM_CH] |=> frame_cnt == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5: a zero high-time never drives the output high.
        a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (on_act[g] == '0) |-> !servo_out[g]);

        // R6: the active high-time does not change inside a running frame.
        a_r6_ontime_held: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[NUM_CH] && !frame_wrap) |=> $stable(on_act[g]));
    end
endmodule

bind servo_pulse_bank servo_pulse_checker #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .servo_out(servo_out), .cfg_q(cfg_q),
    .frame_cnt(frame_cnt), .period_act(period_act),
    .frame_wrap(frame_wrap), .on_act(on_act)
);

// File: tb/sim_servo_pulse_bank.sv
`timescale 1ns/1ps
// Bench for servo_pulse_bank. A small three-channel build is swept over frame
// lengths, high-times and enable patterns and compared with a frame model.
module sim_servo_pulse_bank;
    localparam int NCH    = 3;
    localparam int CW     = 20;
    localparam int DW     = 32;
    localparam int AW     = $clog2(NCH + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NCH-1:0] servo_out;

    int n_chk = 0;
    int n_fail = 0;

    // Model state: written values, values in use, frame position.
    logic [CW-1:0]  m_per, a_per;
    logic [CW-1:0]  m_on [NCH];
    logic [CW-1:0]  a_on [NCH];
    logic [NCH:0]   m_cfg;
    int             pos;

    always #2 clk = ~clk;

    servo_pulse_bank #(.NUM_CH(NCH), .CNT_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .servo_out(servo_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_out();
        logic [31:0] e = '0;
        for (int i = 0; i < NCH; i++)
            e[i] = m_cfg[NCH] && m_cfg[i] && (pos < int'(a_on[i]));
        return e;
    endfunction

    // One rising edge of the model, then the write that edge captures.
    task automatic model_edge(input logic we, input int addr, input logic [31:0] d);
        if (!m_cfg[NCH] || (pos + 1 >= int'(a_per))) begin
            pos = 0;
            a_per = m_per;
            for (int i = 0; i < NCH; i++) a_on[i] = m_on[i];
        end else begin
            pos++;
        end
        if (we) begin
            if (addr == 0) m_per = d[CW-1:0];
            else if (addr == 1) m_cfg = d[NCH:0];
            else if (addr >= 2 && addr < 2 + NCH) m_on[addr-2] = d[CW-1:0];
        end
    endtask

    // Drive at a falling edge, clock once, check at the next falling edge.
    task automatic tick(input logic we, input int addr, input logic [31:0] d, input string req);
        wr_en = we; wr_addr = AW'(addr); wr_data = d;
        @(posedge clk); #1;
        model_edge(we, addr, d);
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, 32'(servo_out), exp_out());
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) tick(1'b0, 0, 0, req);
    endtask

    task automatic rdchk(input int addr, input logic [31:0] exp, input string req);
        rd_addr = AW'(addr);
        #0.2;
        chk(req, rd_data, exp);
    endtask

    task automatic setup(input int p, input int o0, input int o1, input int o2, input string req);
        tick(1'b1, 1, 0, req);
        tick(1'b1, 0, p, req);
        tick(1'b1, 2, o0, req);
        tick(1'b1, 3, o1, req);
        tick(1'b1, 4, o2, req);
    endtask

    // Watchdog: a hung run still counts as a failure and reaches the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_per = '0; a_per = '0; m_cfg = '0; pos = 0;
        for (int i = 0; i < NCH; i++) begin m_on[i] = '0; a_on[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle timer
        chk("R1", 32'(servo_out), 0);
        for (int a = 0; a < 2 + NCH; a++) rdchk(a, 0, "R1");
        idle(4, "R1");

        // R2: register map and readback truncation
        tick(1'b1, 0, 32'd1000000, "R2");
        rdchk(0, 32'd1000000, "R2");
        tick(1'b1, 0, 32'hFFFF_FFFF, "R2");
        rdchk(0, 32'h000F_FFFF, "R2");
        for (int i = 0; i < NCH; i++) begin
            tick(1'b1, 2 + i, 32'h100 + i, "R2");
            rdchk(2 + i, 32'h100 + i, "R2");
        end
        tick(1'b1, 1, 32'hFFFF_FFF5, "R2");
        rdchk(1, 32'h5, "R2");
        tick(1'b1, 1, 32'h0, "R2");
        rdchk(1, 32'h0, "R2");

        // R3 R5: sweep of frame length and high-times, incl. 0 and >= period
        for (int p = 1; p <= 5; p++) begin
            for (int o = 0; o <= p + 1; o++) begin
                setup(p, o, (o + 1) % (p + 2), p + (o % 2), "R3 R5");
                tick(1'b1, 1, 32'hF, "R3 R5");
                idle(2 * p + 3, "R3 R5");
            end
        end

        // R4: every enable pattern, written while running
        setup(4, 2, 3, 1, "R4");
        for (int c = 0; c < 16; c++) begin
            tick(1'b1, 1, c, "R4");
            idle(5, "R4");
        end

        // R6: staged frame length and high-times take effect at the frame start
        setup(6, 3, 5, 1, "R6");
        tick(1'b1, 1, 32'hF, "R6");
        idle(2, "R6");
        tick(1'b1, 0, 3, "R6");
        tick(1'b1, 2, 1, "R6");
        idle(8, "R6");
        tick(1'b1, 0, 7, "R6");
        idle(1, "R6");
        tick(1'b1, 4, 7, "R6");
        tick(1'b1, 3, 0, "R6");
        idle(16, "R6");
        rdchk(0, 7, "R6");

        // R7: clearing the run bit stops and restarts the frame
        idle(3, "R7");
        tick(1'b1, 1, 32'h7, "R7");
        idle(3, "R7");
        tick(1'b1, 2, 5, "R7");
        tick(1'b1, 0, 9, "R7");
        tick(1'b1, 1, 32'hF, "R7");
        idle(20, "R7");

        // R8: unmapped addresses change nothing
        tick(1'b1, 5, 32'hFFFF_FFFF, "R8");
        tick(1'b1, 6, 32'h0, "R8");
        tick(1'b1, 7, 32'h1, "R8");
        idle(10, "R8");
        rdchk(0, 32'(m_per), "R8");
        rdchk(1, 32'(m_cfg), "R8");
        for (int i = 0; i < NCH; i++) rdchk(2 + i, 32'(m_on[i]), "R8");
        rdchk(5, 0, "R8");
        rdchk(7, 0, "R8");

        // R1: reset in the middle of a frame clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_per = '0; a_per = '0; m_cfg = '0; pos = 0;
        for (int i = 0; i < NCH; i++) begin m_on[i] = '0; a_on[i] = '0; end
        chk("R1", 32'(servo_out), 0);
        rdchk(1, 0, "R1");
        rdchk(0, 0, "R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule